// File: doc/BRIEF.md
# Lockable Active-Timer Reset Controller

This block keeps two seconds counters that record how long each of two power domains has been active: the main supply domain and the standby supply domain. A one-cycle tick, once per second, advances each counter while that domain's activity input is high. An 8-bit control register is written and read through a plain register port. Software uses it to request that either counter be zeroed. The request is held as a pending flag, and the counter is zeroed on the next tick.

The register also holds a sticky lock bit. Once the lock is set, every write to the register is dropped, including writes to the lock bit itself and any counter-reset requests. Only two things release the lock. The first is the reset group picked by a configuration input: the main power-up/hardware reset, or the standby power-up reset. The second is a synchronous unlock strobe. The standby counter and its pending flag are cleared only by the standby power-up reset. The main-domain state is cleared by the main reset.

Top module: `acttmr_lock_ctl`

## Requirements
- R1: After both resets, `rd_data` reads 00h and both counters read 0.
- R2: Bit 7 is the lock and is write-1-to-set. A write with bit 7 at 1 sets it and it reads back in bit 7. A write with bit 7 at 0 leaves it as it was.
- R3: While the lock is 1, a register write has no effect. The lock stays 1, and no counter reset is requested by bits 0 or 2.
- R4: When `lock_by_sb` is 0, asserting `rst_main_n` clears the lock and asserting `rst_sb_n` does not. When `lock_by_sb` is 1, the roles of the two resets are swapped.
- R5: A cycle with `unlock_stb` high leaves the lock at 0 afterwards. This holds even if a write with bit 7 at 1 arrives in the same cycle. An unlocked write in that cycle still delivers its bit 0 and bit 2 requests.
- R6: An accepted write with bit 0 at 1 makes the main counter read 0 after the next tick that follows the write cycle. Counting then resumes from 0.
- R7: An accepted write with bit 2 at 1 does the same for the standby counter. The two requests are independent of each other.
- R8: `rd_data` always reads as the lock in bit 7 with zero in bits 6 to 0. The timer-reset bits (0 and 2) and the reserved bits never read back as 1.
- R9: On a tick, each counter adds 1 if its domain-active input is high and no reset is pending for it. Otherwise it holds. A tick that falls in the same cycle as the request write still counts normally. The counter holds in every cycle without a tick.
- R10: `rst_main_n` clears the main counter and its pending request but leaves the standby counter and its request untouched. `rst_sb_n` clears only the standby counter and its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_main_n | input | 1 | Main power-up/hardware reset, async active low |
| rst_sb_n | input | 1 | Standby power-up reset, async active low |
| lock_by_sb | input | 1 | 0: main reset clears the lock; 1: standby reset clears it |
| unlock_stb | input | 1 | Synchronous strobe that clears the lock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read data |
| sec_tick | input | 1 | One-cycle pulse once per second |
| main_active | input | 1 | Main domain is active |
| sb_active | input | 1 | Standby domain is active |
| main_secs | output | CNT_W | Main-domain active-seconds counter |
| sb_secs | output | CNT_W | Standby-domain active-seconds counter |

## Verification
A corrupted lock shows up at once on `rd_data` bit 7 in the cycle after the faulty edge. It also shows up one tick later as a counter that was zeroed when it should not have been, or not zeroed when it should. A lost or stray pending flag is invisible until the next tick, and then shows as a counter at 0 instead of an incremented value, or the other way round. A reset routed to the wrong domain shows as soon as the reset is released, through a counter or lock value that should have survived. The sweeps send all 256 write values through the register in both the unlocked and the locked state, and compare both counters after a tick each time.

// File: rtl/acttmr_pkg.sv
package acttmr_pkg;
  localparam int LOCK_BIT     = 7;
  localparam int SB_RST_BIT   = 2;
  localparam int MAIN_RST_BIT = 0;
  localparam int N_DOM        = 2;
  localparam int DOM_MAIN     = 0;
  localparam int DOM_SB       = 1;
endpackage

// File: rtl/acttmr_ctl_reg.sv
module acttmr_ctl_reg
  import acttmr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             lock_rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             unlock_i,
  output logic             req_main_o,
  output logic             req_sb_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic lock_q, lock_d, lock_en, wr_ok;

  always_comb begin
    wr_ok   = wr_en_i & ~lock_q;
    lock_en = wr_ok | unlock_i;
    lock_d  = lock_q;
    if (wr_ok && wr_data_i[LOCK_BIT]) lock_d = 1'b1;
    if (unlock_i)                     lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge lock_rst_n) begin
    if (!lock_rst_n)  lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  always_comb begin
    req_main_o = wr_ok & wr_data_i[MAIN_RST_BIT];
    req_sb_o   = wr_ok & wr_data_i[SB_RST_BIT];
    rd_data_o  = '0;
    rd_data_o[LOCK_BIT] = lock_q;
  end

  // R3: a set lock survives everything but reset and the strobe
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!lock_rst_n)
    lock_q && !unlock_i |=> lock_q);
  // R2: writing 1 to bit 7 leaves the lock set
  p_w1s_r2: assert property (@(posedge clk) disable iff (!lock_rst_n)
    wr_en_i && wr_data_i[LOCK_BIT] && !unlock_i |=> lock_q);
  // R5: the strobe always releases
  p_unlock_r5: assert property (@(posedge clk) disable iff (!lock_rst_n)
    unlock_i |=> !lock_q);
endmodule

// File: rtl/acttmr_pend.sv
module acttmr_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic tick_i,
  output logic pend_o
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = set_i | tick_i;
    pend_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: a request is held until a tick consumes it
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);
  p_pend_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && tick_i && !set_i |=> !pend_q);
endmodule

// File: rtl/acttmr_counter.sv
module acttmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             active_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = tick_i & (clr_i | active_i);
    cnt_d  = clr_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9: no tick, no change
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  // R9: active tick without pending request adds one
  p_cnt_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !clr_i && active_i |=> cnt_q == $past(cnt_q) + ONE);
  // R6/R7: pending request zeroes on the tick
  p_cnt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && clr_i |=> cnt_q == '0);
endmodule

// File: rtl/acttmr_lock_ctl.sv
module acttmr_lock_ctl
  import acttmr_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_main_n,
  input  logic             rst_sb_n,
  input  logic             lock_by_sb,
  input  logic             unlock_stb,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sec_tick,
  input  logic             main_active,
  input  logic             sb_active,
  output logic [CNT_W-1:0] main_secs,
  output logic [CNT_W-1:0] sb_secs
);
  logic             lock_rst_n;
  logic [N_DOM-1:0] dom_rst_n, dom_req, dom_pend, dom_act;
  logic [CNT_W-1:0] dom_cnt [N_DOM];

  always_comb begin
    lock_rst_n         = lock_by_sb ? rst_sb_n : rst_main_n;
    dom_rst_n[DOM_MAIN] = rst_main_n;
    dom_rst_n[DOM_SB]   = rst_sb_n;
    dom_act[DOM_MAIN]   = main_active;
    dom_act[DOM_SB]     = sb_active;
  end

  acttmr_ctl_reg #(.REG_W(REG_W)) u_reg (
    .clk        (clk),
    .lock_rst_n (lock_rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .unlock_i   (unlock_stb),
    .req_main_o (dom_req[DOM_MAIN]),
    .req_sb_o   (dom_req[DOM_SB]),
    .rd_data_o  (rd_data)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    acttmr_pend u_pend (
      .clk    (clk),
      .rst_n  (dom_rst_n[d]),
      .set_i  (dom_req[d]),
      .tick_i (sec_tick),
      .pend_o (dom_pend[d])
    );
    acttmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (dom_rst_n[d]),
      .tick_i   (sec_tick),
      .clr_i    (dom_pend[d]),
      .active_i (dom_act[d]),
      .cnt_o    (dom_cnt[d])
    );
  end

  assign main_secs = dom_cnt[DOM_MAIN];
  assign sb_secs   = dom_cnt[DOM_SB];
endmodule

// File: tb/acttmr_lock_ctl_tb_top.sv
module acttmr_lock_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_main_n, rst_sb_n, lock_by_sb, unlock_stb, wr_en;
  logic [7:0]  wr_data, rd_data;
  logic        sec_tick, main_active, sb_active;
  logic [31:0] main_secs, sb_secs;

  int total = 0, bad = 0;
  bit done = 0;

  logic        m_lock, m_pm, m_ps;
  logic [31:0] m_main, m_sb;

  always #4 clk = ~clk;

  acttmr_lock_ctl dut_i (
    .clk(clk), .rst_main_n(rst_main_n), .rst_sb_n(rst_sb_n),
    .lock_by_sb(lock_by_sb), .unlock_stb(unlock_stb), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sec_tick(sec_tick),
    .main_active(main_active), .sb_active(sb_active),
    .main_secs(main_secs), .sb_secs(sb_secs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(rd_data == {m_lock, 7'b0}, req, "rd_data", 32'(rd_data), 32'({m_lock, 7'b0}));
    chk(main_secs == m_main, req, "main_secs", main_secs, m_main);
    chk(sb_secs == m_sb, req, "sb_secs", sb_secs, m_sb);
  endtask

  // One clock cycle of stimulus; inputs driven and outputs sampled at negedge.
  task automatic cyc(input bit wr, input logic [7:0] d, input bit tk,
                     input bit ma, input bit sa, input bit unl, input string req);
    bit ok_wr;
    wr_en = wr; wr_data = d; sec_tick = tk;
    main_active = ma; sb_active = sa; unlock_stb = unl;
    @(negedge clk);
    wr_en = 0; sec_tick = 0; unlock_stb = 0;
    ok_wr = wr && !m_lock;
    if (tk) begin
      m_main = m_pm ? 32'd0 : (ma ? m_main + 1 : m_main);
      m_sb   = m_ps ? 32'd0 : (sa ? m_sb + 1 : m_sb);
    end
    m_pm = (ok_wr && d[0]) ? 1'b1 : (tk ? 1'b0 : m_pm);
    m_ps = (ok_wr && d[2]) ? 1'b1 : (tk ? 1'b0 : m_ps);
    if (unl) m_lock = 0;
    else if (ok_wr && d[7]) m_lock = 1;
    check_all(req);
  endtask

  task automatic pulse_rst(input bit main_not_sb, input string req);
    if (main_not_sb) rst_main_n = 0; else rst_sb_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_main_n = 1; rst_sb_n = 1;
    if (main_not_sb) begin
      m_main = 0; m_pm = 0;
      if (!lock_by_sb) m_lock = 0;
    end else begin
      m_sb = 0; m_ps = 0;
      if (lock_by_sb) m_lock = 0;
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_main_n = 0; rst_sb_n = 0; lock_by_sb = 0; unlock_stb = 0;
    wr_en = 0; wr_data = 0; sec_tick = 0; main_active = 0; sb_active = 0;
    m_lock = 0; m_pm = 0; m_ps = 0; m_main = 0; m_sb = 0;
    repeat (3) @(negedge clk);
    rst_main_n = 1; rst_sb_n = 1;
    @(negedge clk);
    check_all("R1");

    // R9: counting patterns, holds without tick or without activity
    for (int i = 0; i < 12; i++)
      cyc(0, 8'h00, (i % 3) != 2, i[0], i[1], 0, "R9");

    // R2 R6 R7 R8 R5: every write value while unlocked
    for (int v = 0; v < 256; v++) begin
      cyc(1, 8'(v), 0, 1, 1, 0, "R8");
      cyc(0, 8'h00, 1, 1, 1, 0, "R6");
      cyc(0, 8'h00, 1, 1, 0, 0, "R7");
      if (m_lock) cyc(0, 8'h00, 0, 0, 0, 1, "R5");
    end

    // R3: every write value while locked
    cyc(1, 8'h80, 0, 0, 0, 0, "R2");
    for (int v = 0; v < 256; v++) begin
      cyc(1, 8'(v), 0, 1, 1, 0, "R3");
      cyc(0, 8'h00, 1, 1, 1, 0, "R3");
    end

    // R5: strobe together with a write, locked then unlocked
    cyc(1, 8'h85, 0, 0, 0, 1, "R5");
    cyc(0, 8'h00, 1, 1, 1, 0, "R5");
    cyc(1, 8'h85, 0, 0, 0, 1, "R5");
    cyc(0, 8'h00, 1, 1, 1, 0, "R5");

    // R9: request written in the tick cycle, zeroed on the following tick
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 1, 1, 0, "R9");
    cyc(1, 8'h05, 1, 1, 1, 0, "R9");
    cyc(0, 8'h00, 0, 1, 1, 0, "R9");
    cyc(0, 8'h00, 1, 1, 1, 0, "R9");
    cyc(0, 8'h00, 1, 1, 1, 0, "R9");

    // R4 R10: lock cleared by main reset group
    for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, 1, 1, 0, "R10");
    lock_by_sb = 0;
    cyc(1, 8'h84, 0, 0, 0, 0, "R4");
    pulse_rst(0, "R4");
    cyc(0, 8'h00, 1, 1, 1, 0, "R10");
    pulse_rst(1, "R4");
    cyc(0, 8'h00, 1, 1, 1, 0, "R10");

    // R4 R10: lock cleared by standby reset group; pending survives other reset
    lock_by_sb = 1;
    cyc(1, 8'h85, 0, 0, 0, 0, "R4");
    pulse_rst(1, "R10");
    cyc(0, 8'h00, 1, 1, 1, 0, "R10");
    cyc(0, 8'h00, 1, 1, 1, 0, "R10");
    cyc(1, 8'h81, 0, 0, 0, 0, "R4");
    pulse_rst(0, "R4");
    cyc(0, 8'h00, 1, 1, 1, 0, "R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule